// File: doc/BRIEF.md
# Addressed Serial-Load Register Bank

This block is a slave on a three-wire serial link made of a serial clock, a data line and a load strobe. It keeps a bank of eight 8-bit holding registers, whose values are all brought out in parallel. A 12-bit shift register collects one word at a time, formed of a register address and then a data byte. When the load strobe rises, the address is decoded and the data byte is written into that one register. The other registers are left as they are. Several address codes select nothing, which lets a controller skip a bank in a chain of them.

The stage that leaves the shift register last drives a serial output. Any bank can therefore pass its stream on to the next bank, and a chain of banks loads from one long stream followed by one common strobe. The serial pins and the strobe are asynchronous to the system clock. They go through synchronisers, and serial-clock edges are found on the system clock. An active-low preset input forces every register to mid-scale (0x80) at once, without waiting for a clock edge.

Top module: `serial_trim_bank`

## Requirements
- R1: After system reset the eight registers read 0x80 and the serial output reads 0.
- R2: A word is 12 bits, sent most significant bit first: a 4-bit address, then an 8-bit data byte. After a load, the addressed register holds exactly that byte.
- R3: Address 1 through 8 selects register 0 through 7, which is slice [8*k+7:8*k] of the parallel output for register k. A load changes only the selected register.
- R4: Address 0 and addresses 9 through 15 select nothing. A load with such an address changes no register.
- R5: While the synchronised strobe is high, serial-clock edges are ignored and the shift register keeps its contents.
- R6: A strobe that stays high for many system clocks performs one update, on its rising edge. A preset that is released while the strobe is still high is therefore not overwritten.
- R7: A low preset sets all registers to 0x80 at once, without a system clock edge. A load while the preset is low has no effect.
- R8: The serial output is the registered last stage of the shift register. A bit shifted in shows up at the serial output after exactly twelve serial-clock rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous system reset |
| ser_clk | input | 1 | Serial clock; data is shifted on its rising edge |
| ser_din | input | 1 | Serial data in |
| ser_load | input | 1 | Load strobe; active high, acts on its rising edge |
| preset_n | input | 1 | Active-low asynchronous preset to mid-scale |
| ser_dout | output | 1 | Serial data out, for chaining banks |
| reg_vals | output | 64 | All eight registers, register k at [8k+7:8k] |

## Verification
All sixteen address codes are swept with a data byte derived from each address. A model array updated arithmetically in the bench shows at once whether a write went to the wrong slot, to several slots, or to no slot. Bytes 0x00, 0xFF, 0x01 and 0x7E written to each register separate bit-order and bit-stuck faults from decode faults. A 24-bit stream with no repeating pattern, compared bit by bit at the serial output, pins the twelve-edge delay to a single position. Shifting a different word while the strobe is held, and releasing the preset while the strobe is still high, each tell a level-sensitive design apart from an edge-triggered one.

// File: rtl/trim_bank_pkg.sv
package trim_bank_pkg;
   localparam int unsigned DEF_ADDR_W   = 4;
   localparam int unsigned DEF_DATA_W   = 8;
   localparam int unsigned DEF_NUM_REGS = 8;
   localparam int unsigned DEF_STAGES   = 2;

   // Mid-scale code for a data width: only the top bit is set.
   function automatic logic [31:0] midscale(input int unsigned width);
      return 32'(1) << (width - 1);
   endfunction
endpackage

// File: rtl/tb_sync_bit.sv
module tb_sync_bit #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("tb_sync_bit: at least two stages are required");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= 1'b0;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/serial_front.sv
module serial_front #(
   parameter int unsigned WORD_W = 12,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   input  logic              ser_load,
   output logic [WORD_W-1:0] word,
   output logic              dout,
   output logic              load_stb
);
   logic sclk_s, sdin_s, sld_s;
   logic sclk_q, sld_q;
   logic shift_en;
   logic [WORD_W-1:0] sr;

   tb_sync_bit #(.STAGES(STAGES)) u_sync_clk (.clk(clk), .rst_n(rst_n), .d(ser_clk),  .q(sclk_s));
   tb_sync_bit #(.STAGES(STAGES)) u_sync_din (.clk(clk), .rst_n(rst_n), .d(ser_din),  .q(sdin_s));
   tb_sync_bit #(.STAGES(STAGES)) u_sync_ld  (.clk(clk), .rst_n(rst_n), .d(ser_load), .q(sld_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         sld_q  <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         sld_q  <= sld_s;
      end
   end

   // A serial-clock rise shifts only while the strobe is low.
   assign shift_en = sclk_s && !sclk_q && !sld_s;
   assign load_stb = sld_s && !sld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else if (shift_en) sr <= {sr[WORD_W-2:0], sdin_s};
   end

   assign word = sr;
   assign dout = sr[WORD_W-1];

   assert_hold_under_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sld_s |=> $stable(sr));
   assert_dout_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> dout == $past(sr[WORD_W-2]));
   assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> !load_stb);
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_REGS = 8,
   parameter logic [DATA_W-1:0] PRESET = 8'h80,
   localparam int unsigned WORD_W = ADDR_W + DATA_W
) (
   input  logic                       clk,
   input  logic                       arst_n,
   input  logic                       load_stb,
   input  logic [WORD_W-1:0]          word,
   output logic [NUM_REGS*DATA_W-1:0] regs
);
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] data;
   logic [NUM_REGS-1:0] sel;
   logic addr_ok;

   assign addr = word[WORD_W-1 -: ADDR_W];
   assign data = word[DATA_W-1:0];

   generate
      for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
         // Code 0 is reserved, so register k answers to code k+1.
         assign sel[k] = (addr == ADDR_W'(k + 1));

         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) regs[k*DATA_W +: DATA_W] <= PRESET;
            else if (load_stb && sel[k]) regs[k*DATA_W +: DATA_W] <= data;
         end
      end
   endgenerate

   assign addr_ok = |sel;

   assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!arst_n)
      $onehot0(sel));
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!arst_n)
      !load_stb |=> $stable(regs));
   assert_noop_stable_R4: assert property (@(posedge clk) disable iff (!arst_n)
      (load_stb && !addr_ok) |=> $stable(regs));
   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!arst_n)
      (load_stb && sel[0]) |=> regs[DATA_W-1:0] == $past(data));
endmodule

// File: rtl/serial_trim_bank.sv
module serial_trim_bank
   import trim_bank_pkg::*;
#(
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned DATA_W   = DEF_DATA_W,
   parameter int unsigned NUM_REGS = DEF_NUM_REGS,
   parameter int unsigned STAGES   = DEF_STAGES,
   localparam int unsigned WORD_W  = ADDR_W + DATA_W,
   localparam logic [DATA_W-1:0] PRESET = DATA_W'(midscale(DATA_W))
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ser_clk,
   input  logic                       ser_din,
   input  logic                       ser_load,
   input  logic                       preset_n,
   output logic                       ser_dout,
   output logic [NUM_REGS*DATA_W-1:0] reg_vals
);
   logic [WORD_W-1:0] word;
   logic load_stb;
   logic bank_arst_n;

   generate
      if (NUM_REGS + 1 > (1 << ADDR_W)) begin : g_addr_small
         $error("serial_trim_bank: address field cannot reach every register");
      end
      if (DATA_W < 2 || DATA_W > 32) begin : g_data_range
         $error("serial_trim_bank: DATA_W must be 2..32");
      end
   endgenerate

   assign bank_arst_n = rst_n & preset_n;

   serial_front #(.WORD_W(WORD_W), .STAGES(STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
      .ser_load(ser_load), .word(word), .dout(ser_dout), .load_stb(load_stb));

   reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .PRESET(PRESET)) u_bank (
      .clk(clk), .arst_n(bank_arst_n), .load_stb(load_stb), .word(word), .regs(reg_vals));

   assert_preset_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !preset_n |-> reg_vals == {NUM_REGS{PRESET}});
endmodule

// File: tb/serial_trim_bank_bench.sv
module serial_trim_bank_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_din = 1'b0, ser_load = 1'b0, preset_n = 1'b1;
   logic ser_dout;
   logic [63:0] reg_vals;
   logic [7:0] model [8];
   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   serial_trim_bank u_serial_trim_bank (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
      .ser_load(ser_load), .preset_n(preset_n), .ser_dout(ser_dout), .reg_vals(reg_vals));

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int k = 0; k < 8; k++) check(req, reg_vals[k*8 +: 8], model[k]);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      ser_din = b;
      ser_clk = 1'b1;
      wait_n(4);
      ser_clk = 1'b0;
      wait_n(4);
   endtask

   task automatic send_word(input logic [3:0] a, input logic [7:0] d);
      logic [11:0] w;
      w = {a, d};
      for (int i = 11; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic pulse_load();
      ser_load = 1'b1;
      wait_n(6);
      ser_load = 1'b0;
      wait_n(6);
   endtask

   task automatic write_model(input logic [3:0] a, input logic [7:0] d);
      if (a >= 1 && a <= 8) model[a-1] = d;
   endtask

   initial begin
      #(5.0 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [23:0] stream;
      for (int k = 0; k < 8; k++) model[k] = 8'h80;
      wait_n(4);
      rst_n = 1'b1;
      wait_n(2);
      // R1: reset state
      check_all("R1 reset value");
      check("R1 sdo reset", {7'd0, ser_dout}, 8'd0);

      // R2 R3 R4: sweep all sixteen codes
      for (int a = 0; a < 16; a++) begin
         logic [7:0] d;
         d = 8'((a * 37) ^ 8'h5A);
         send_word(4'(a), d);
         pulse_load();
         write_model(4'(a), d);
         check_all((a >= 1 && a <= 8) ? "R3 address map" : "R4 no-op code");
      end

      // R2: data patterns per register
      for (int k = 0; k < 8; k++) begin
         logic [7:0] pats [4];
         pats = '{8'h00, 8'hFF, 8'h01, 8'h7E};
         for (int p = 0; p < 4; p++) begin
            send_word(4'(k + 1), pats[p]);
            pulse_load();
            write_model(4'(k + 1), pats[p]);
            check_all("R2 data byte");
         end
      end

      // R5: shifting while the strobe is held must not disturb the word
      send_word(4'd2, 8'h11);
      ser_load = 1'b1;
      wait_n(6);
      model[1] = 8'h11;
      send_word(4'd2, 8'h99);
      ser_load = 1'b0;
      wait_n(6);
      pulse_load();
      check("R5 shift held under strobe", reg_vals[15:8], 8'h11);

      // R6: preset released while strobe stays high
      send_word(4'd1, 8'h33);
      pulse_load();
      check("R6 setup", reg_vals[7:0], 8'h33);
      ser_load = 1'b1;
      wait_n(6);
      preset_n = 1'b0;
      wait_n(3);
      preset_n = 1'b1;
      wait_n(12);
      check("R6 single update", reg_vals[7:0], 8'h80);
      ser_load = 1'b0;
      wait_n(6);
      for (int k = 0; k < 8; k++) model[k] = 8'h80;
      check_all("R6 bank after preset");

      // R7: preset acts before any clock edge, and blocks loads
      send_word(4'd8, 8'hC4);
      pulse_load();
      check("R7 setup", reg_vals[63:56], 8'hC4);
      #1 preset_n = 1'b0;
      #0.5 check("R7 async preset", reg_vals[63:56], 8'h80);
      wait_n(1);
      ser_load = 1'b1;
      wait_n(6);
      ser_load = 1'b0;
      wait_n(6);
      preset_n = 1'b1;
      wait_n(2);
      model[7] = 8'h80;
      check_all("R7 load ignored under preset");

      // R8: twelve-edge pass-through
      stream = 24'hA5C396;
      for (int e = 1; e <= 24; e++) begin
         send_bit(stream[24 - e]);
         if (e >= 12) check("R8 sdo delay", {7'd0, ser_dout}, {7'd0, stream[24 - (e - 11)]});
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule